// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital control core of a successive-approximation analog-to-digital converter with a 14-bit result. It waits in an acquire phase, in which the sampling switches connect the differential inputs to the hold capacitors and the comparator auto-zero switches are closed. A conversion begins on the clock cycle in which chip select and convert request first become true together. The block then opens both switch groups and searches for the input level one bit at a time. It drives a trial code to the capacitor DAC and reads a single comparator decision per bit.

After the least significant decision, one further cycle copies the finished code into an output register. In that cycle the busy flag drops and a one-cycle done pulse appears. The DAC, the comparator and the reference are outside the block and connect only through ports. Three rules protect a conversion in progress. A new request during a conversion is dropped. A request that comes before the configured minimum acquire time has passed is also dropped. A request held high does not trigger a second conversion.

Top module: `sar_conv_seq`

## Requirements
- R1: While the synchronous active-low reset is low, and on the first cycle after it, busy is 0, done is 0, the output register and the DAC code are 0, and both switch controls are 1 (acquire phase). A reset during a conversion aborts it.
- R2: A conversion is accepted only on a clock edge where (chip select AND convert request) is 1 and was 0 on the previous edge. A request with chip select low, or a condition held high after a conversion finishes, starts nothing. Busy reads 1 in the cycle after the accepting edge.
- R3: A start edge is honoured only after ACQ_CYCLES (default 8) full idle cycles have passed since busy fell or reset was released. An earlier edge is dropped and not remembered.
- R4: Start edges that arrive while busy is 1 are ignored. The conversion in progress keeps its length and its result.
- R5: At the accepting edge the approximation register is cleared. In the first busy cycle the DAC code is exactly 0x2000, with only the most significant bit set, whatever the previous result was.
- R6: Bits are decided from bit 13 down to bit 0, one per cycle. In busy cycle k (k = 0..13), the DAC code holds the decided upper bits, then a 1 at bit 13-k, then zeros below. A comparator value of 1 sampled at the end of that cycle keeps bit 13-k; a value of 0 clears it.
- R7: Sample-switch and auto-zero outputs are 1 whenever busy is 0 and are 0 whenever busy is 1.
- R8: Busy stays 1 for exactly 15 cycles: 14 decision cycles and one latch cycle. The output register holds its old value while busy is 1 and takes the new result in the first cycle busy is 0. Done is 1 in that cycle only.
- R9: The latched result equals the final approximation code. With a comparator that reports input >= DAC code, it equals the applied input code, including 0 and 16383.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| cnv_i | input | 1 | Convert request, active high |
| cmp_i | input | 1 | Comparator decision, 1 when input >= DAC level |
| dac_code_o | output | 14 | Trial code for the capacitor DAC |
| smp_sw_o | output | 1 | Sample switches connect the inputs when 1 |
| zero_sw_o | output | 1 | Comparator auto-zero switches closed when 1 |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the result register updates |
| result_o | output | 14 | Latched conversion result |

## Verification
The acquire-time counter reaching its limit and a fresh start edge can fall on the same clock edge, and that edge must start a conversion. An edge one cycle earlier must be dropped for good. The bench lets a conversion finish and then raises the start condition exactly ACQ_CYCLES-1 idle cycles later in one run, expecting busy to stay low while the condition is held, and exactly ACQ_CYCLES cycles later in another run, expecting busy to be high on the very next cycle. A second coincidence is a start edge arriving while busy is 1. The bench provokes it by toggling the convert request in the middle of a conversion, then checks that busy lasts 15 cycles and that the scoreboard still receives the original input code.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      PH_ACQ   = 2'd0,
      PH_CONV  = 2'd1,
      PH_LATCH = 2'd2
   } phase_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/sar_start_gate.sv
module sar_start_gate #(
   parameter int unsigned ACQ_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic cnv_i,
   input  logic idle_i,
   output logic accept_o
);
   logic req;
   logic req_q;
   logic acq_ok;

   assign req = cs_i & cnv_i;

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req;
   end

   generate
      if (ACQ_CYCLES == 0) begin : g_no_acq
         assign acq_ok = 1'b1;
      end else begin : g_acq_cnt
         localparam int unsigned CW = sar_seq_pkg::cnt_width(ACQ_CYCLES);
         localparam logic [CW-1:0] LIMIT = CW'(ACQ_CYCLES);
         logic [CW-1:0] acq_q;

         always_ff @(posedge clk) begin
            if (!rst_n)             acq_q <= '0;
            else if (!idle_i)       acq_q <= '0;
            else if (acq_q != LIMIT) acq_q <= acq_q + 1'b1;
         end

         assign acq_ok = (acq_q == LIMIT);
      end
   endgenerate

   assign accept_o = req & ~req_q & idle_i & acq_ok;

endmodule

// File: rtl/sar_bit_stepper.sv
module sar_bit_stepper #(
   parameter int unsigned DATA_W       = 14,
   parameter bit          KEEP_ON_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic              cmp_i,
   output logic [DATA_W-1:0] code_o,
   output logic              lsb_o
);
   localparam logic [DATA_W-1:0] TOP_ONE = {1'b1, {(DATA_W-1){1'b0}}};

   logic [DATA_W-1:0] code_q;
   logic [DATA_W-1:0] mask_q;
   logic              keep;

   generate
      if (KEEP_ON_HIGH) begin : g_keep_high
         assign keep = cmp_i;
      end else begin : g_keep_low
         assign keep = ~cmp_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         mask_q <= '0;
      end else if (load_i) begin
         code_q <= TOP_ONE;
         mask_q <= TOP_ONE;
      end else if (step_i) begin
         code_q <= (keep ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
         mask_q <= mask_q >> 1;
      end
   end

   assign code_o = code_q;
   assign lsb_o  = mask_q[0];

endmodule

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 accept_i,
   input  logic                 lsb_i,
   output sar_seq_pkg::phase_t  phase_o,
   output logic                 load_o,
   output logic                 step_o,
   output logic                 latch_o
);
   import sar_seq_pkg::*;

   phase_t ph_q;
   phase_t ph_d;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_ACQ:   if (accept_i) ph_d = PH_CONV;
         PH_CONV:  if (lsb_i)    ph_d = PH_LATCH;
         PH_LATCH:               ph_d = PH_ACQ;
         default:                ph_d = PH_ACQ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= PH_ACQ;
      else        ph_q <= ph_d;
   end

   assign phase_o = ph_q;
   assign load_o  = (ph_q == PH_ACQ) & accept_i;
   assign step_o  = (ph_q == PH_CONV);
   assign latch_o = (ph_q == PH_LATCH);

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
   parameter int unsigned DATA_W       = 14,
   parameter int unsigned ACQ_CYCLES   = 8,
   parameter bit          KEEP_ON_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              cnv_i,
   input  logic              cmp_i,
   output logic [DATA_W-1:0] dac_code_o,
   output logic              smp_sw_o,
   output logic              zero_sw_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] result_o
);
   import sar_seq_pkg::*;

   generate
      if (DATA_W < 2 || DATA_W > 32) begin : g_bad_width
         $error("sar_conv_seq: DATA_W must lie in 2..32");
      end
      if (ACQ_CYCLES > 65535) begin : g_bad_acq
         $error("sar_conv_seq: ACQ_CYCLES too large");
      end
   endgenerate

   phase_t            phase;
   logic              idle;
   logic              accept;
   logic              load;
   logic              step;
   logic              latch;
   logic              lsb;
   logic [DATA_W-1:0] code;
   logic [DATA_W-1:0] res_q;
   logic              done_q;

   assign idle = (phase == PH_ACQ);

   sar_start_gate #(
      .ACQ_CYCLES (ACQ_CYCLES)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_i     (cs_i),
      .cnv_i    (cnv_i),
      .idle_i   (idle),
      .accept_o (accept)
   );

   sar_phase_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .lsb_i    (lsb),
      .phase_o  (phase),
      .load_o   (load),
      .step_o   (step),
      .latch_o  (latch)
   );

   sar_bit_stepper #(
      .DATA_W       (DATA_W),
      .KEEP_ON_HIGH (KEEP_ON_HIGH)
   ) u_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .step_i (step),
      .cmp_i  (cmp_i),
      .code_o (code),
      .lsb_o  (lsb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= latch;
         if (latch) res_q <= code;
      end
   end

   assign dac_code_o = code;
   assign smp_sw_o   = idle;
   assign zero_sw_o  = idle;
   assign busy_o     = ~idle;
   assign done_o     = done_q;
   assign result_o   = res_q;

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
   parameter int unsigned DATA_W     = 14,
   parameter int unsigned ACQ_CYCLES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] dac_code_o,
   input logic              smp_sw_o,
   input logic              zero_sw_o,
   input logic              busy_o,
   input logic              done_o,
   input logic [DATA_W-1:0] result_o
);
   localparam int unsigned BUSY_LEN = DATA_W + 1;
   localparam logic [DATA_W-1:0] TOP_ONE = {1'b1, {(DATA_W-1){1'b0}}};
   localparam int unsigned GW = $clog2(ACQ_CYCLES + 3);

   int unsigned   busy_cnt;
   logic [GW-1:0] gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      busy_cnt <= 0;
      else if (busy_o) busy_cnt <= busy_cnt + 1;
      else             busy_cnt <= 0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        gap_q <= '0;
      else if (busy_o)                   gap_q <= '0;
      else if (gap_q != GW'(ACQ_CYCLES + 1)) gap_q <= gap_q + 1'b1;
   end

   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (!busy_o && !done_o && result_o == '0));

   p_acq_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (gap_q > GW'(ACQ_CYCLES)));

   p_fixed_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (busy_cnt < BUSY_LEN));

   p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (dac_code_o == TOP_ONE));

   p_switch_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (!smp_sw_o && !zero_sw_o));

   p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> $stable(result_o));

   p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

endmodule

bind sar_conv_seq sar_conv_seq_chk #(
   .DATA_W     (DATA_W),
   .ACQ_CYCLES (ACQ_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dac_code_o (dac_code_o),
   .smp_sw_o   (smp_sw_o),
   .zero_sw_o  (zero_sw_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .result_o   (result_o)
);

// File: tb/sim_sar_conv_seq.sv
`timescale 1ns/1ps
module sim_sar_conv_seq;
   localparam int W   = 14;
   localparam int ACQ = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs = 1'b0;
   logic         cnv = 1'b0;
   logic [W-1:0] vin = '0;
   logic         cmp;
   logic [W-1:0] dac;
   logic         smp_sw, zero_sw, busy, done;
   logic [W-1:0] result;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   int exp_q[$];

   always #5 clk = ~clk;

   assign cmp = (vin >= dac);

   sar_conv_seq #(.DATA_W(W), .ACQ_CYCLES(ACQ)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .cnv_i(cnv), .cmp_i(cmp),
      .dac_code_o(dac), .smp_sw_o(smp_sw), .zero_sw_o(zero_sw),
      .busy_o(busy), .done_o(done), .result_o(result)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         chk(1'b0, "R8 watchdog", cyc, 150000);
         summary();
         $finish;
      end
   end

   // scoreboard monitor: R9
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) chk(1'b0, "R9 unexpected result", int'(result), -1);
         else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(result) == e, "R9 result", int'(result), e);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // full trace of one conversion, start condition left high afterwards
   task automatic conv_traced(input int v);
      int prev;
      @(negedge clk);
      vin = W'(v); exp_q.push_back(v); prev = int'(result);
      cs = 1'b1; cnv = 1'b1;
      @(negedge clk);
      for (int k = 0; k < W; k++) begin
         int hi, e;
         hi = (~((1 << (W - k)) - 1)) & ((1 << W) - 1);
         e  = (v & hi) | (1 << (W - 1 - k));
         if (k == 0) chk(int'(dac) == 8192, "R5 first code", int'(dac), 8192);
         chk(int'(dac) == e, "R6 trial code", int'(dac), e);
         chk(busy == 1'b1, "R8 busy during decision", busy, 1);
         chk(!smp_sw && !zero_sw, "R7 switches open", {smp_sw, zero_sw}, 0);
         chk(int'(result) == prev, "R8 result held", int'(result), prev);
         @(negedge clk);
      end
      chk(busy == 1'b1 && done == 1'b0, "R8 latch cycle busy", {busy, done}, 2);
      chk(int'(result) == prev, "R8 result held in latch cycle", int'(result), prev);
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b1, "R8 busy fall with done", {busy, done}, 1);
      chk(smp_sw && zero_sw, "R7 switches back to acquire", {smp_sw, zero_sw}, 3);
      @(negedge clk);
      chk(done == 1'b0, "R8 done single cycle", done, 0);
   endtask

   // conversion with busy counting; optional retrigger mid-flight
   task automatic conv_run(input int v, input bit retrig, output int nbusy);
      int guard;
      nbusy = 0; guard = 0;
      @(negedge clk);
      vin = W'(v); exp_q.push_back(v);
      cs = 1'b1; cnv = 1'b1;
      do begin
         @(negedge clk);
         guard++;
         if (busy) nbusy++;
         if (retrig && nbusy == 5) cnv = 1'b0;
         if (retrig && nbusy == 6) cnv = 1'b1;
      end while (!done && guard < 40);
      cs = 1'b0; cnv = 1'b0;
   endtask

   initial begin
      int nb;
      // R1 reset state
      repeat (4) @(negedge clk);
      chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
      chk(result == '0 && dac == '0, "R1 reset data", int'(result), 0);
      chk(smp_sw && zero_sw, "R1 reset acquire switches", {smp_sw, zero_sw}, 3);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && result == '0, "R1 first cycle after reset", busy, 0);
      idle(ACQ + 2);

      // traced conversion, then held start must not retrigger (R2)
      conv_traced(10838);
      for (int i = 0; i < ACQ + 6; i++) begin
         @(negedge clk);
         chk(busy == 1'b0, "R2 held start no retrigger", busy, 0);
      end
      cs = 1'b0; cnv = 1'b0;
      idle(ACQ + 2);

      // corner codes (R9) and fixed length (R8)
      conv_run(0, 1'b0, nb);
      chk(nb == 15, "R8 busy length code 0", nb, 15);
      idle(ACQ + 2);
      conv_run(16383, 1'b0, nb);
      chk(nb == 15, "R8 busy length full scale", nb, 15);
      idle(ACQ + 2);
      conv_traced(5461);
      cs = 1'b0; cnv = 1'b0;
      idle(ACQ + 2);
      conv_run(8191, 1'b0, nb);
      idle(ACQ + 2);

      // retrigger during busy (R4)
      conv_run(1234, 1'b1, nb);
      chk(nb == 15, "R4 retrigger ignored length", nb, 15);
      idle(ACQ + 2);

      // chip select low (R2)
      cs = 1'b0;
      @(negedge clk); cnv = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(busy == 1'b0, "R2 no start without chip select", busy, 0);
      end
      cnv = 1'b0;
      idle(ACQ + 2);

      // too-early start (R3)
      conv_run(5000, 1'b0, nb);
      idle(ACQ - 1);
      cs = 1'b1; cnv = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk(busy == 1'b0, "R3 early start dropped", busy, 0);
      end
      cs = 1'b0; cnv = 1'b0;
      idle(ACQ + 2);

      // exact acquire boundary (R3)
      conv_run(700, 1'b0, nb);
      idle(ACQ);
      vin = W'(333); exp_q.push_back(333);
      cs = 1'b1; cnv = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1, "R3 start at acquire limit", busy, 1);
      for (int i = 0; i < 20 && !done; i++) @(negedge clk);
      cs = 1'b0; cnv = 1'b0;
      idle(ACQ + 2);

      // reset aborts a conversion (R1)
      vin = W'(9999);
      cs = 1'b1; cnv = 1'b1;
      idle(5);
      chk(busy == 1'b1, "R2 conversion running", busy, 1);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!busy && result == '0 && smp_sw, "R1 reset aborts", int'(result), 0);
      cs = 1'b0; cnv = 1'b0;
      rst_n = 1'b1;
      idle(3);
      chk(done == 1'b0 && busy == 1'b0, "R1 no result after abort", {busy, done}, 0);

      chk(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
      summary();
      $finish;
   end

endmodule